// File: doc/BRIEF.md
# Per-Pin Interrupt Condition Detector

This block turns a stream of sampled input bits into interrupts. The inputs are captured serially elsewhere in the chip. Each new sample of all input slots arrives on `sample_bits`, marked by a one-cycle `sample_valid` strobe. The slots are grouped into banks of 32. For every slot, software selects a trigger condition: falling edge, rising edge, both edges, high level or low level. When that condition is seen, a sticky pending bit is set.

Each bank has five registers on a simple register bus: an enable mask, three trigger-type masks (polarity, level-select and dual-edge) and a pending-status mask that software clears by writing ones. The single `irq` output is high while any pending bit in any bank has its enable bit set. Slots above `NUM_INPUTS` do not exist and can never become pending.

Top module: `irqdet_top`

## Requirements
- R1: After reset, every enable, polarity, level-select, dual-edge and status register reads 0, and `irq` is 0.
- R2: Bank b has its register group at byte address 0x04 + 0x1C*b. Within the group, the enable mask is at +0x0, the polarity mask at +0x4, the level-select mask at +0x8, the dual-edge mask at +0xC and the status mask at +0x10. A write to enable, polarity, level-select or dual-edge stores the full 32-bit word, which then reads back unchanged. Reads of unmapped addresses return 0.
- R3: With level-select=0, dual-edge=0 and polarity=0 on a slot, its status bit is set by a strobe whose sample is 0 when the previous strobe's sample was 1. A 0-to-1 change does not set it.
- R4: With polarity=1, level-select=0 and dual-edge=0, a slot's status bit is set on a 0-to-1 change between strobes and not on a 1-to-0 change.
- R5: With dual-edge=1 and level-select=0, a slot's status bit is set on a change in either direction between strobes.
- R6: With level-select=1, a slot's status bit is set on every strobe whose sample equals its polarity bit (1 = high level, 0 = low level). A clear does not hold while the level persists and strobes continue.
- R7: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When a detection and a clearing status write hit the same bit in the same cycle, the bit ends up set.
- R9: A status bit is set whether or not it is enabled. `irq` is 1 exactly when some status bit and its enable bit are both 1, and it follows writes to either register in the cycle after the write.
- R10: Status bits of slots at or above `NUM_INPUTS` always read 0, whatever trigger mode is selected for them.
- R11: Conditions are evaluated only on `sample_valid` cycles, and input changes between strobes have no effect. The first strobe after reset only records the baseline for edge detection and raises no edge events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Register byte address, for reads and writes |
| bus_wdata | input | BANK_W (32) | Write data |
| bus_rdata | output | BANK_W (32) | Read data for `bus_addr` (combinational) |
| sample_valid | input | 1 | One-cycle strobe that marks a new sample |
| sample_bits | input | NUM_INPUTS (80) | Sampled input slots |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `sample_valid` is a clean single-cycle pulse. They also assume that register writes and strobes are driven synchronously and never hold X after reset. The interrupt-follow check additionally relies on the enable mask being stable in the cycle where a detection lands. For that reason it is waived in cycles with a bus write, and the bench keeps to this rule by never changing enables on a strobe cycle. The bench drives every input one time unit after a rising edge. It issues each write or strobe for exactly one cycle, with idle cycles between them, so every detection is attributable to one known previous sample.

// File: rtl/irqdet_pkg.sv
package irqdet_pkg;

  // Register selector within one bank's group.
  typedef enum logic [2:0] {
    RS_ENABLE = 3'd0,
    RS_POL    = 3'd1,
    RS_LEVEL  = 3'd2,
    RS_DUAL   = 3'd3,
    RS_STATUS = 3'd4,
    RS_NONE   = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    TRIG_FALL  = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_kind_e;

  // Byte offset inside a bank group -> register selector.
  function automatic reg_sel_e offset_to_sel(input logic [15:0] off);
    case (off)
      16'h0000: return RS_ENABLE;
      16'h0004: return RS_POL;
      16'h0008: return RS_LEVEL;
      16'h000C: return RS_DUAL;
      16'h0010: return RS_STATUS;
      default:  return RS_NONE;
    endcase
  endfunction

  // Three mask bits -> trigger kind; level select dominates, then dual edge.
  function automatic trig_kind_e decode_trig(input logic pol, input logic lvl,
                                             input logic dual);
    if (lvl)       return TRIG_LEVEL;
    else if (dual) return TRIG_BOTH;
    else if (pol)  return TRIG_RISE;
    else           return TRIG_FALL;
  endfunction

  // Does one slot meet its condition on this sample?
  function automatic logic cond_fires(input logic pol, input logic lvl,
                                      input logic dual, input logic prev,
                                      input logic cur, input logic edge_ok);
    case (decode_trig(pol, lvl, dual))
      TRIG_LEVEL: return cur == pol;
      TRIG_BOTH:  return edge_ok && (prev != cur);
      TRIG_RISE:  return edge_ok && !prev && cur;
      default:    return edge_ok && prev && !cur;
    endcase
  endfunction

endpackage

// File: rtl/irqdet_decode.sv
module irqdet_decode
  import irqdet_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 8,
  parameter int BASE0     = 'h04,
  parameter int STRIDE    = 'h1C
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output reg_sel_e             sel
);

  reg_sel_e bank_sel [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gen_bank
    localparam logic [ADDR_W-1:0] BASE_B = ADDR_W'(BASE0 + b * STRIDE);
    logic [ADDR_W-1:0] off;
    assign off         = addr - BASE_B;
    assign bank_sel[b] = (addr >= BASE_B) ? offset_to_sel(16'(off)) : RS_NONE;
    assign bank_hit[b] = (bank_sel[b] != RS_NONE);
  end

  always_comb begin
    sel = RS_NONE;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) sel = bank_sel[b];
    end
  end

endmodule

// File: rtl/irqdet_bank.sv
module irqdet_bank
  import irqdet_pkg::*;
#(
  parameter int BANK_W     = 32,
  parameter int BANK_IDX   = 0,
  parameter int NUM_INPUTS = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [BANK_W-1:0] wdata,
  input  logic              sample_valid,
  input  logic [BANK_W-1:0] sample_in,
  input  logic              edge_ok,
  output logic [BANK_W-1:0] rdata,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] stat_o,
  output logic [BANK_W-1:0] hit_o,
  output logic [BANK_W-1:0] valid_o
);

  logic [BANK_W-1:0] en_q, pol_q, lvl_q, dual_q, stat_q, prev_q;
  logic [BANK_W-1:0] valid_mask, hit, clr, stat_next;

  // Slot existence and per-slot condition detection.
  for (genvar i = 0; i < BANK_W; i++) begin : gen_slot
    localparam bit SLOT_EXISTS = (BANK_IDX * BANK_W + i) < NUM_INPUTS;
    assign valid_mask[i] = SLOT_EXISTS;
    assign hit[i] = valid_mask[i] && sample_valid &&
                    cond_fires(pol_q[i], lvl_q[i], dual_q[i], prev_q[i],
                               sample_in[i], edge_ok);
  end

  assign clr       = (wr_en && sel == RS_STATUS) ? wdata : '0;
  // Detection is ORed after the clear, so it wins on the same bit.
  assign stat_next = ((stat_q & ~clr) | hit) & valid_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      lvl_q  <= '0;
      dual_q <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      if (wr_en) begin
        case (sel)
          RS_ENABLE: en_q   <= wdata;
          RS_POL:    pol_q  <= wdata;
          RS_LEVEL:  lvl_q  <= wdata;
          RS_DUAL:   dual_q <= wdata;
          default:   ;
        endcase
      end
      if (sample_valid) prev_q <= sample_in;
      stat_q <= stat_next;
    end
  end

  always_comb begin
    case (sel)
      RS_ENABLE: rdata = en_q;
      RS_POL:    rdata = pol_q;
      RS_LEVEL:  rdata = lvl_q;
      RS_DUAL:   rdata = dual_q;
      RS_STATUS: rdata = stat_q;
      default:   rdata = '0;
    endcase
  end

  assign en_o    = en_q;
  assign stat_o  = stat_q;
  assign hit_o   = hit;
  assign valid_o = valid_mask;

endmodule

// File: rtl/irqdet_top.sv
module irqdet_top
  import irqdet_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_W     = 32,
  parameter int NUM_INPUTS = 80,
  parameter int ADDR_W     = 8,
  parameter int BASE0      = 'h04,
  parameter int STRIDE     = 'h1C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BANK_W-1:0]     bus_wdata,
  output logic [BANK_W-1:0]     bus_rdata,
  input  logic                  sample_valid,
  input  logic [NUM_INPUTS-1:0] sample_bits,
  output logic                  irq
);

  localparam int FLAT_W = NUM_BANKS * BANK_W;

  logic [NUM_BANKS-1:0] bank_hit;
  reg_sel_e             sel;
  logic [BANK_W-1:0]    bank_rdata [NUM_BANKS];
  logic [FLAT_W-1:0]    samples_pad;
  logic [FLAT_W-1:0]    status_flat, enable_flat, hit_flat, valid_flat;
  logic                 primed_q;

  assign samples_pad = FLAT_W'(sample_bits);

  // The first strobe after reset only sets the edge baseline.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            primed_q <= 1'b0;
    else if (sample_valid) primed_q <= 1'b1;
  end

  irqdet_decode #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BASE0(BASE0), .STRIDE(STRIDE)
  ) u_decode (
    .addr(bus_addr), .bank_hit(bank_hit), .sel(sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gen_bank
    irqdet_bank #(
      .BANK_W(BANK_W), .BANK_IDX(b), .NUM_INPUTS(NUM_INPUTS)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (bus_wr && bank_hit[b]),
      .sel         (sel),
      .wdata       (bus_wdata),
      .sample_valid(sample_valid),
      .sample_in   (samples_pad[b*BANK_W +: BANK_W]),
      .edge_ok     (primed_q),
      .rdata       (bank_rdata[b]),
      .en_o        (enable_flat[b*BANK_W +: BANK_W]),
      .stat_o      (status_flat[b*BANK_W +: BANK_W]),
      .hit_o       (hit_flat[b*BANK_W +: BANK_W]),
      .valid_o     (valid_flat[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) bus_rdata = bus_rdata | bank_rdata[b];
    end
  end

  assign irq = |(status_flat & enable_flat);

endmodule

// File: rtl/irqdet_checker.sv
module irqdet_checker #(
  parameter int FLAT_W = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              sample_valid,
  input logic              irq,
  input logic [FLAT_W-1:0] status_flat,
  input logic [FLAT_W-1:0] enable_flat,
  input logic [FLAT_W-1:0] hit_flat,
  input logic [FLAT_W-1:0] valid_flat
);

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(hit_flat & enable_flat)) && !bus_wr) |=> irq);

  assert_invalid_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_flat & ~valid_flat) == '0);

  assert_hit_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> (hit_flat == '0));

  assert_hit_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flat != '0) |=> ((status_flat & $past(hit_flat)) == $past(hit_flat)));

  assert_status_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_flat & ~$past(status_flat) & ~$past(hit_flat)) == '0);

endmodule

bind irqdet_top irqdet_checker #(.FLAT_W(FLAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .sample_valid(sample_valid),
  .irq(irq), .status_flat(status_flat), .enable_flat(enable_flat),
  .hit_flat(hit_flat), .valid_flat(valid_flat)
);

// File: tb/irqdet_top_bench.sv
module irqdet_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NIN = 80;

  localparam int OFF_EN = 0, OFF_POL = 4, OFF_LVL = 8, OFF_DUAL = 12, OFF_ST = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            sample_valid = 1'b0;
  logic [NIN-1:0]  sample_bits = '0;
  logic            irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [NIN-1:0] smp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqdet_top u_irqdet_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_valid(sample_valid),
    .sample_bits(sample_bits), .irq(irq)
  );

  function automatic logic [7:0] ra(input int bank, input int off);
    return 8'(4 + 28 * bank + off);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_reg(input string req, input int bank, input int off, input logic [31:0] exp);
    logic [31:0] d;
    rd(ra(bank, off), d);
    check(req, d, exp);
  endtask

  task automatic strobe();
    sample_bits = smp; sample_valid = 1'b1;
    tick();
    sample_valid = 1'b0;
    tick();
  endtask

  task automatic clear_all();
    for (int b = 0; b < 3; b++) wr(ra(b, OFF_ST), 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    for (int b = 0; b < 3; b++)
      for (int o = 0; o <= 16; o += 4) chk_reg("R1", b, o, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_baseline();
    wr(ra(0, OFF_POL), 32'hFFFF_FFFF);
    smp = '1;
    strobe();
    check("R11 first strobe", 0, 0);
    chk_reg("R11 first strobe no edge", 0, OFF_ST, 32'h0);
    smp[0] = 1'b0; sample_bits = smp;
    tick(); tick(); tick();
    smp[0] = 1'b1; sample_bits = smp;
    tick();
    chk_reg("R11 no strobe no effect", 0, OFF_ST, 32'h0);
    smp[0] = 1'b0; strobe();
    smp[0] = 1'b1; strobe();
    chk_reg("R11 strobed edge seen", 0, OFF_ST, 32'h1);
    wr(ra(0, OFF_ST), 32'hFFFF_FFFF);
    wr(ra(0, OFF_POL), 32'h0);
  endtask

  task automatic t_map();
    for (int b = 0; b < 3; b++) begin
      wr(ra(b, OFF_EN),   32'hA5000000 | 32'(b));
      wr(ra(b, OFF_POL),  32'h5A000010 | 32'(b));
      wr(ra(b, OFF_LVL),  32'h3C000020 | 32'(b));
      wr(ra(b, OFF_DUAL), 32'hC3000030 | 32'(b));
    end
    for (int b = 0; b < 3; b++) begin
      chk_reg("R2 enable",  b, OFF_EN,   32'hA5000000 | 32'(b));
      chk_reg("R2 polarity", b, OFF_POL,  32'h5A000010 | 32'(b));
      chk_reg("R2 level",   b, OFF_LVL,  32'h3C000020 | 32'(b));
      chk_reg("R2 dual",    b, OFF_DUAL, 32'hC3000030 | 32'(b));
    end
    begin
      logic [31:0] d;
      rd(8'h00, d); check("R2 unmapped 0x00", d, 32'h0);
      rd(8'h18, d); check("R2 unmapped 0x18", d, 32'h0);
    end
    for (int b = 0; b < 3; b++)
      for (int o = 0; o <= 12; o += 4) wr(ra(b, o), 32'h0);
  endtask

  task automatic t_falling();
    smp[5] = 1'b0; smp[40] = 1'b0;
    strobe();
    chk_reg("R3 fall bank0", 0, OFF_ST, 32'h20);
    chk_reg("R3 fall bank1", 1, OFF_ST, 32'h100);
    clear_all();
    smp[5] = 1'b1; smp[40] = 1'b1;
    strobe();
    chk_reg("R3 rise ignored b0", 0, OFF_ST, 32'h0);
    chk_reg("R3 rise ignored b1", 1, OFF_ST, 32'h0);
  endtask

  task automatic t_rising();
    wr(ra(1, OFF_POL), 32'hFFFF_FFFF);
    smp[40] = 1'b0; strobe();
    chk_reg("R4 fall ignored", 1, OFF_ST, 32'h0);
    smp[40] = 1'b1; strobe();
    chk_reg("R4 rise seen", 1, OFF_ST, 32'h100);
    clear_all();
    wr(ra(1, OFF_POL), 32'h0);
  endtask

  task automatic t_both();
    wr(ra(0, OFF_POL), 32'hFFFF_FFFF);
    wr(ra(0, OFF_DUAL), 32'hFFFF_FFFF);
    smp[7] = 1'b0; strobe();
    chk_reg("R5 falling half", 0, OFF_ST, 32'h80);
    clear_all();
    smp[7] = 1'b1; strobe();
    chk_reg("R5 rising half", 0, OFF_ST, 32'h80);
    clear_all();
    wr(ra(0, OFF_POL), 32'h0);
    wr(ra(0, OFF_DUAL), 32'h0);
  endtask

  task automatic t_level();
    wr(ra(0, OFF_LVL), 32'hFFFF_FFFF);
    wr(ra(0, OFF_POL), 32'h1);
    strobe();
    chk_reg("R6 high level", 0, OFF_ST, 32'h1);
    wr(ra(0, OFF_ST), 32'h1);
    chk_reg("R6 cleared between strobes", 0, OFF_ST, 32'h0);
    strobe();
    chk_reg("R6 level re-sets", 0, OFF_ST, 32'h1);
    smp[0] = 1'b0; smp[1] = 1'b0; strobe();
    chk_reg("R6 low level adds", 0, OFF_ST, 32'h3);
    clear_all();
    strobe();
    chk_reg("R6 low level persists", 0, OFF_ST, 32'h2);
    wr(ra(0, OFF_LVL), 32'h0);
    wr(ra(0, OFF_POL), 32'h0);
    clear_all();
    smp[0] = 1'b1; smp[1] = 1'b1; strobe();
    chk_reg("R6 restored", 0, OFF_ST, 32'h0);
  endtask

  task automatic t_w1c();
    smp[32] = 1'b0; smp[33] = 1'b0; smp[34] = 1'b0;
    strobe();
    chk_reg("R7 setup", 1, OFF_ST, 32'h7);
    wr(ra(1, OFF_ST), 32'h5);
    chk_reg("R7 partial clear", 1, OFF_ST, 32'h2);
    wr(ra(1, OFF_ST), 32'h0);
    chk_reg("R7 zero write keeps", 1, OFF_ST, 32'h2);
    wr(ra(1, OFF_ST), 32'h2);
    chk_reg("R7 final clear", 1, OFF_ST, 32'h0);
    smp[32] = 1'b1; smp[33] = 1'b1; smp[34] = 1'b1;
    strobe();
  endtask

  task automatic t_race();
    wr(ra(1, OFF_LVL), 32'h10);
    smp[36] = 1'b0; strobe();
    chk_reg("R8 setup", 1, OFF_ST, 32'h10);
    wr(ra(1, OFF_ST), 32'h10);
    chk_reg("R8 clear alone", 1, OFF_ST, 32'h0);
    bus_addr = ra(1, OFF_ST); bus_wdata = 32'h10; bus_wr = 1'b1;
    sample_bits = smp; sample_valid = 1'b1;
    tick();
    bus_wr = 1'b0; sample_valid = 1'b0;
    chk_reg("R8 detection wins", 1, OFF_ST, 32'h10);
    wr(ra(1, OFF_LVL), 32'h0);
    clear_all();
    smp[36] = 1'b1; strobe();
    chk_reg("R8 restored", 1, OFF_ST, 32'h0);
  endtask

  task automatic t_irq();
    check("R9 idle", 32'(irq), 32'h0);
    smp[64] = 1'b0; strobe();
    chk_reg("R9 status without enable", 2, OFF_ST, 32'h1);
    check("R9 masked", 32'(irq), 32'h0);
    wr(ra(2, OFF_EN), 32'h1);
    check("R9 enable raises", 32'(irq), 32'h1);
    wr(ra(2, OFF_ST), 32'h1);
    check("R9 clear drops", 32'(irq), 32'h0);
    smp[64] = 1'b1; strobe();
    wr(ra(0, OFF_EN), 32'h40);
    smp[6] = 1'b0; strobe();
    check("R9 enabled detection", 32'(irq), 32'h1);
    wr(ra(0, OFF_EN), 32'h0);
    check("R9 disable drops", 32'(irq), 32'h0);
    chk_reg("R9 status kept", 0, OFF_ST, 32'h40);
    wr(ra(2, OFF_EN), 32'h0);
    clear_all();
    smp[6] = 1'b1; strobe();
  endtask

  task automatic t_invalid();
    wr(ra(2, OFF_LVL), 32'hFFFF_FFFF);
    strobe();
    chk_reg("R10 absent slots quiet", 2, OFF_ST, 32'h0);
    smp[79] = 1'b0; strobe();
    chk_reg("R10 top valid slot", 2, OFF_ST, 32'h8000);
    wr(ra(2, OFF_LVL), 32'h0);
    clear_all();
    smp[79] = 1'b1; strobe();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_baseline();
    t_map();
    t_falling();
    t_rising();
    t_both();
    t_level();
    t_w1c();
    t_race();
    t_irq();
    t_invalid();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule